// File: doc/BRIEF.md
# OLED Panel Power-Up Sequencer

This block brings a small colour OLED display controller out of reset and into a state where it accepts pixel data. A pulse on `start` begins the bring-up. The block first drives the panel reset line high and then low, holding each level for a programmable number of clock cycles. It then steps through a fixed script of 23 register index/value pairs. Each pair goes out as a command byte followed by a data byte, through a downstream serial byte writer. After the last pair it sends one lone command byte that opens the controller's pixel-data port. It then raises `done` and holds it there.

Every byte is offered on a valid/ready request port. The byte writer takes a byte by asserting `req_ready` while `req_valid` is high. It reports that the transfer on the wire has finished with a one-cycle `wr_done` pulse. The sequencer never offers the next byte before that pulse arrives. The first two pairs put the controller's oscillator and drive current into a known state. Each of these pairs is followed by a 5 ms settling pause. The length of the pause in cycles is derived from a clock-frequency parameter.

Back-pressure rules: once `req_valid` rises, it stays high, and `req_byte` and `req_is_cmd` stay unchanged, until the cycle in which `req_ready` is sampled high. That cycle is the handshake. `req_valid` then drops and stays low at least until `wr_done` has been seen.

Top module: `oled_bringup_seq`

## Requirements
- R1: After reset, with `start` low, `panel_rst`, `req_valid` and `done` are all 0. Nothing is requested.
- R2: A `start` pulse taken in the idle or finished state sets `panel_rst` high for exactly RST_HI_CYC cycles, and then low for exactly RST_LO_CYC cycles. No request is made in that time. The first request follows at once.
- R3: The bytes are offered in exactly this order, 47 in all.
  - Each of the following pairs is sent as its index with `req_is_cmd`=1, then its value with `req_is_cmd`=0: 04/03, 04/00, 3B/00, 02/01, 03/90, 80/01, 08/04, 09/05, 0A/05, 0B/9D, 0C/8C, 0D/57, 10/56, 11/4D, 12/46, 13/00, 14/01, 16/66, 28/7F, 29/00, 06/01, 05/00, 15/00 (hex).
  - A final 0x22 follows with `req_is_cmd`=1 and no data byte.
  - Pair 03/90 sets a 120 frame/s refresh and pair 28/7F sets 1/128 duty.
- R4: While `req_valid` is high and `req_ready` is low, `req_valid` stays high, and `req_byte` and `req_is_cmd` do not change.
- R5: After a handshake, `req_valid` stays low until a `wr_done` pulse has been received.
- R6: `req_valid` stays low for exactly PAUSE_CYC = CLK_HZ/1000*PAUSE_MS cycles after the `wr_done` of the data byte of the first pair. The same holds after the data byte of the second pair. After every other `wr_done`, the next byte is offered in the very next cycle.
- R7: `done` rises in the cycle after the `wr_done` of the final 0x22 byte. It then stays high, with `req_valid` and `panel_rst` low, until reset or a new `start`. That `start` clears `done` and begins a new bring-up at once.
- R8: A `start` pulse during a bring-up in progress has no effect.
- R9: A `wr_done` pulse that arrives while no transfer is outstanding is ignored. This covers pulses during the reset pulse, during a pending offer, and after `done` has risen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin (or restart) the bring-up |
| panel_rst | output | 1 | Reset line to the display controller |
| req_valid | output | 1 | A byte is offered to the byte writer |
| req_ready | input | 1 | Byte writer accepts the offered byte |
| req_is_cmd | output | 1 | 1 = command/index byte, 0 = data byte |
| req_byte | output | 8 | Byte offered to the byte writer |
| wr_done | input | 1 | One-cycle pulse: previous transfer finished |
| done | output | 1 | Controller is configured and ready for pixels |

## Verification
The hardest situations to reach are stray strobes that arrive while the sequencer is not waiting for them. Examples are a `wr_done` during the reset pulse or while an offer is still unaccepted, and a `start` between a handshake and its completion. The directed runs reach them by holding `req_ready` low for several cycles and by stretching the writer's completion latency. This opens windows in which the bench injects those strobes. It then confirms that all 47 bytes still arrive in order, with the reset line untouched. The two settling pauses are measured by counting idle cycles at the request port, with the clock parameter lowered so that each pause lasts 1000 cycles.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

  localparam int NUM_PAIRS    = 23;
  localparam int PAUSED_PAIRS = 2;
  localparam logic [7:0] PIXEL_PORT_IDX = 8'h22;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_HI, S_RST_LO, S_IDX, S_IDX_WAIT,
    S_VAL, S_VAL_WAIT, S_PAUSE, S_OPEN, S_OPEN_WAIT, S_DONE
  } seq_state_t;

  typedef struct packed {
    logic [7:0] idx;
    logic [7:0] val;
  } reg_pair_t;

  // Bring-up script; the order is part of the behaviour.
  function automatic reg_pair_t script_pair(input logic [7:0] step);
    reg_pair_t p;
    case (step)
      8'd0:  p = '{8'h04, 8'h03};
      8'd1:  p = '{8'h04, 8'h00};
      8'd2:  p = '{8'h3B, 8'h00};
      8'd3:  p = '{8'h02, 8'h01};
      8'd4:  p = '{8'h03, 8'h90};   // 120 frames per second
      8'd5:  p = '{8'h80, 8'h01};
      8'd6:  p = '{8'h08, 8'h04};
      8'd7:  p = '{8'h09, 8'h05};
      8'd8:  p = '{8'h0A, 8'h05};
      8'd9:  p = '{8'h0B, 8'h9D};
      8'd10: p = '{8'h0C, 8'h8C};
      8'd11: p = '{8'h0D, 8'h57};
      8'd12: p = '{8'h10, 8'h56};
      8'd13: p = '{8'h11, 8'h4D};
      8'd14: p = '{8'h12, 8'h46};
      8'd15: p = '{8'h13, 8'h00};
      8'd16: p = '{8'h14, 8'h01};
      8'd17: p = '{8'h16, 8'h66};
      8'd18: p = '{8'h28, 8'h7F};   // 1/128 duty
      8'd19: p = '{8'h29, 8'h00};
      8'd20: p = '{8'h06, 8'h01};
      8'd21: p = '{8'h05, 8'h00};
      default: p = '{8'h15, 8'h00};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/oled_script_rom.sv
module oled_script_rom
  import oled_seq_pkg::*;
#(
  parameter int STEP_W = 5
) (
  input  logic [STEP_W-1:0] step,
  output reg_pair_t         pair,
  output logic              pause_after,
  output logic              last_pair
);

  always_comb begin
    pair        = script_pair(8'(step));
    pause_after = (step < STEP_W'(PAUSED_PAIRS));
    last_pair   = (step == STEP_W'(NUM_PAIRS - 1));
  end

endmodule

// File: rtl/oled_step_timer.sv
module oled_step_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/oled_bringup_seq.sv
module oled_bringup_seq
  import oled_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned PAUSE_MS   = 5,
  parameter int unsigned RST_HI_CYC = 16,
  parameter int unsigned RST_LO_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       panel_rst,
  output logic       req_valid,
  input  logic       req_ready,
  output logic       req_is_cmd,
  output logic [7:0] req_byte,
  input  logic       wr_done,
  output logic       done
);

  localparam int STEP_W = $clog2(NUM_PAIRS);
  localparam int unsigned PAUSE_RAW = (CLK_HZ / 1000) * PAUSE_MS;
  localparam int unsigned PAUSE_CYC = (PAUSE_RAW < 1) ? 1 : PAUSE_RAW;
  localparam int unsigned HI_CYC    = (RST_HI_CYC < 1) ? 1 : RST_HI_CYC;
  localparam int unsigned LO_CYC    = (RST_LO_CYC < 1) ? 1 : RST_LO_CYC;
  localparam int unsigned MAX_A     = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int unsigned MAX_CYC   = (MAX_A > PAUSE_CYC) ? MAX_A : PAUSE_CYC;
  localparam int TMR_W = $clog2(MAX_CYC + 1);

  seq_state_t        state, state_nx;
  logic [STEP_W-1:0] step;
  logic              step_clr, step_inc;
  reg_pair_t         pair;
  logic              pause_after, last_pair;
  logic              tmr_load, tmr_expired;
  logic [TMR_W-1:0]  tmr_val;
  logic              handshake;

  oled_script_rom #(.STEP_W(STEP_W)) u_rom (
    .step        (step),
    .pair        (pair),
    .pause_after (pause_after),
    .last_pair   (last_pair)
  );

  oled_step_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign handshake = req_valid && req_ready;

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    step_clr = 1'b0;
    step_inc = 1'b0;
    case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          state_nx = S_RST_HI;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(HI_CYC - 1);
          step_clr = 1'b1;
        end
      end
      S_RST_HI: begin
        if (tmr_expired) begin
          state_nx = S_RST_LO;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(LO_CYC - 1);
        end
      end
      S_RST_LO:   if (tmr_expired) state_nx = S_IDX;
      S_IDX:      if (handshake)   state_nx = S_IDX_WAIT;
      S_IDX_WAIT: if (wr_done)     state_nx = S_VAL;
      S_VAL:      if (handshake)   state_nx = S_VAL_WAIT;
      S_VAL_WAIT: begin
        if (wr_done) begin
          if (pause_after) begin
            state_nx = S_PAUSE;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(PAUSE_CYC - 1);
          end else if (last_pair) begin
            state_nx = S_OPEN;
          end else begin
            state_nx = S_IDX;
            step_inc = 1'b1;
          end
        end
      end
      S_PAUSE: begin
        if (tmr_expired) begin
          state_nx = S_IDX;
          step_inc = 1'b1;
        end
      end
      S_OPEN:      if (handshake) state_nx = S_OPEN_WAIT;
      S_OPEN_WAIT: if (wr_done)   state_nx = S_DONE;
      default:     state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      step  <= '0;
    end else begin
      state <= state_nx;
      if (step_clr)      step <= '0;
      else if (step_inc) step <= step + 1'b1;
    end
  end

  always_comb begin
    panel_rst  = (state == S_RST_HI);
    done       = (state == S_DONE);
    req_valid  = (state == S_IDX) || (state == S_VAL) || (state == S_OPEN);
    req_is_cmd = (state != S_VAL);
    if (state == S_VAL)       req_byte = pair.val;
    else if (state == S_OPEN) req_byte = PIXEL_PORT_IDX;
    else                      req_byte = pair.idx;
  end

endmodule

// File: rtl/oled_seq_checker.sv
module oled_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       panel_rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_is_cmd,
  input logic [7:0] req_byte,
  input logic       wr_done,
  input logic       done
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n)                     outstanding <= 1'b0;
    else if (req_valid && req_ready) outstanding <= 1'b1;
    else if (wr_done)               outstanding <= 1'b0;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_byte) && $stable(req_is_cmd)));

  assert_wait_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !req_valid);

  assert_quiet_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    panel_rst |-> !req_valid);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req_valid && !panel_rst));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && panel_rst));

endmodule

bind oled_bringup_seq oled_seq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .panel_rst  (panel_rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_is_cmd (req_is_cmd),
  .req_byte   (req_byte),
  .wr_done    (wr_done),
  .done       (done)
);

// File: tb/oled_bringup_seq_bench.sv
module oled_bringup_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 200_000;
  localparam int PAUSE_MS   = 5;
  localparam int HI_CYC     = 4;
  localparam int LO_CYC     = 6;
  localparam int PAUSE_CYC  = CLK_HZ / 1000 * PAUSE_MS;
  localparam int NBYTES     = 47;
  localparam int WATCHDOG   = 150_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       req_ready = 1'b0;
  logic       wr_done = 1'b0;
  logic       panel_rst, req_valid, req_is_cmd, done;
  logic [7:0] req_byte;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [7:0] exp_idx [23] = '{8'h04, 8'h04, 8'h3B, 8'h02, 8'h03, 8'h80, 8'h08, 8'h09,
                              8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h10, 8'h11, 8'h12, 8'h13,
                              8'h14, 8'h16, 8'h28, 8'h29, 8'h06, 8'h05, 8'h15};
  logic [7:0] exp_val [23] = '{8'h03, 8'h00, 8'h00, 8'h01, 8'h90, 8'h01, 8'h04, 8'h05,
                              8'h05, 8'h9D, 8'h8C, 8'h57, 8'h56, 8'h4D, 8'h46, 8'h00,
                              8'h01, 8'h66, 8'h7F, 8'h00, 8'h01, 8'h00, 8'h00};

  oled_bringup_seq #(
    .CLK_HZ(CLK_HZ), .PAUSE_MS(PAUSE_MS), .RST_HI_CYC(HI_CYC), .RST_LO_CYC(LO_CYC)
  ) u_oled_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .panel_rst(panel_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_cmd(req_is_cmd),
    .req_byte(req_byte), .wr_done(wr_done), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  // R1: quiet after reset
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!panel_rst && !req_valid && !done, "R1 idle outputs",
            {panel_rst, req_valid, done}, 0);
    end
  endtask

  // Full bring-up with a byte-writer model; R2..R9
  task automatic t_run(input int rdelay, input int lat, input bit inject);
    int hi, lo, gap;
    logic [7:0] eb, held;
    logic ec;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(panel_rst && !done, "R7 start clears done and raises reset",
          {panel_rst, done}, 2'b10);
    hi = 0;
    while (panel_rst && hi < 100) begin
      hi++;
      wr_done = (inject && hi == 1);   // R9 stray completion during reset pulse
      check(!req_valid, "R2 no request during reset", req_valid, 0);
      @(negedge clk);
    end
    wr_done = 1'b0;
    check(hi == HI_CYC, "R2 reset high length", hi, HI_CYC);
    lo = 0;
    while (!req_valid && lo < 100) begin
      lo++;
      @(negedge clk);
    end
    check(lo == LO_CYC, "R2 reset low length", lo, LO_CYC);

    for (int b = 0; b < NBYTES; b++) begin
      if (b > 0) begin
        gap = 0;
        while (!req_valid && gap < 5000) begin
          gap++;
          @(negedge clk);
        end
        if (b == 2 || b == 4)
          check(gap == PAUSE_CYC, "R6 settling pause", gap, PAUSE_CYC);
        else
          check(gap == 0, "R6 no pause", gap, 0);
      end
      if (b == NBYTES - 1) begin eb = 8'h22; ec = 1'b1; end
      else if (b % 2 == 0) begin eb = exp_idx[b/2]; ec = 1'b1; end
      else begin eb = exp_val[b/2]; ec = 1'b0; end
      check(req_valid && req_byte == eb && req_is_cmd == ec && !panel_rst,
            $sformatf("R3 byte %0d", b), {req_is_cmd, req_byte}, {ec, eb});
      held = req_byte;
      for (int d = 0; d < rdelay; d++) begin
        wr_done = (inject && d == 0);  // R9 stray completion while offer pending
        @(negedge clk);
        check(req_valid && req_byte == held, "R4 hold under back-pressure",
              {req_valid, req_byte}, {1'b1, held});
      end
      wr_done = 1'b0;
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      check(!req_valid, "R5 idle after handshake", req_valid, 0);
      for (int k = 0; k < lat; k++) begin
        start = (inject && k == 0);    // R8 start ignored mid-run
        @(negedge clk);
        check(!req_valid && !panel_rst, "R5 R8 wait for completion",
              {req_valid, panel_rst}, 0);
      end
      start = 1'b0;
      wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
    end
    check(done && !req_valid, "R7 done after final byte", {done, req_valid}, 2'b10);
  endtask

  // R7 done sticks; R9 stray completions ignored once finished
  task automatic t_done_hold();
    for (int i = 0; i < 20; i++) begin
      wr_done = (i % 3 == 0);
      @(negedge clk);
      check(done && !req_valid && !panel_rst, "R7 R9 done holds",
            {done, req_valid, panel_rst}, 3'b100);
    end
    wr_done = 1'b0;
  endtask

  initial begin
    t_reset();
    t_run(0, 1, 1'b0);
    t_done_hold();
    t_run(3, 4, 1'b1);
    t_done_hold();
    t_run(1, 2, 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule